// File: doc/BRIEF.md
# Two-Word Command Port Decoder

This block sits behind the control port of a video controller. Each 16-bit word written there is either a register write, which leaves as a one-cycle write strobe with an index and a value, or one half of a two-word access command. Such a command loads a 16-bit access address and a 6-bit access code. The top two address bits are captured from the second word and kept for every later command, so a first word on its own moves only within the current 16 KiB window. Data-port reads and writes advance the address by an auto-increment value that the register file supplies.

When the second word of a command asks for a DMA, the block decides which kind may start. It does this from the new code, the DMA-enable mode bit and a two-bit mode field from the register file. It then emits a start pulse with the kind and the transfer length. A fill does not start at once: it is armed, and it starts on the next data-port write. While a DMA still has transfers to do, a new first control word is parked in a one-word holding slot. It is applied in the first cycle after the DMA finishes in which no data-port access is present.

The sequencing is a four-state machine. IDLE waits for a first word. HALF means a first word has been taken and the second is awaited. FILL means a fill is armed and no command half is open. FILL_HALF means a fill is armed and a command half is open. The transitions are as follows:
- IDLE goes to HALF on a first word that is not a register write.
- HALF goes to IDLE on a second word that does not arm a fill, or on a status read or any data access.
- HALF goes to FILL on a second word that arms a fill.
- FILL goes to FILL_HALF on a first word that is not a register write.
- FILL goes to IDLE on a data write, which starts the fill.
- FILL_HALF goes to FILL on a second word, a status read or a data read.
- FILL_HALF goes to IDLE on a data write, which starts the fill.

Top module: `cmd_port_decoder`

## Requirements
- R1: After synchronous reset, addr, code, pending, reg_we, reg_idx, reg_data, dma_start, dma_kind and dma_len are all zero.
- R2: When pending is 0, a word whose bits [15:14] are 2'b10 is a register write. One cycle later reg_we pulses for exactly one cycle, with reg_idx = word[12:8] and reg_data = word[7:0], and pending stays 0.
- R3: A first word (pending 0) sets addr to {held top bits, word[13:0]} and code[1:0] to word[15:14], and leaves code[5:2] unchanged. Unless the word is a register write, pending becomes 1.
- R4: A second word (pending 1) clears pending, latches word[1:0] as the held top bits, and sets addr[15:14] from them. It also sets code[5:2] to word[7:4] and leaves code[1:0] unchanged.
- R5: A status read (stat_rd) or any data-port access clears pending.
- R6: A register write with an index above 10 produces no reg_we unless ext_regs is 1.
- R7: A DMA can start from a second word only when the new code[5] is 1 and dma_enable is 1. Mode values 2'b00 and 2'b01 start a transfer at once: dma_start pulses the cycle after, with dma_kind equal to the mode value.
- R8: Mode 2'b10 with new code[3:0] = 4'h1 arms a fill and starts nothing. The next data write then pulses dma_start with dma_kind 2'b10 and leaves addr unchanged. Later data writes advance addr and start nothing. With any other code, no fill is armed.
- R9: Mode 2'b11 starts a transfer with dma_kind 2'b11 only when new code[4:0] = 5'h10. Any other code starts nothing.
- R10: dma_len takes dma_len_field at the start, and a field of zero gives 65536.
- R11: A first word written while dma_active is 1 changes neither addr, code nor pending. A later word written in that time replaces it. The held word is applied in the cycle after dma_active falls.
- R12: A control write arriving in the cycle a held word is applied is queued and applied one cycle later. A data access present when the held word would be applied is served first, and the held word follows one cycle later.
- R13: A data access that does not start a fill adds auto_inc to addr modulo 65536 and does not change the held top bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_word | input | 16 | Control-port write data |
| stat_rd | input | 1 | Status-port read strobe |
| data_rd | input | 1 | Data-port read strobe |
| data_wr | input | 1 | Data-port write strobe |
| auto_inc | input | 8 | Address increment applied per data access |
| ext_regs | input | 1 | Mode bit that allows writes to registers above index 10 |
| dma_enable | input | 1 | DMA-enable mode bit |
| dma_mode | input | 2 | DMA kind field from the register file |
| dma_len_field | input | 16 | Programmed DMA length, zero meaning 65536 |
| dma_active | input | 1 | A DMA still has transfers remaining |
| addr | output | 16 | Access address register |
| code | output | 6 | Access code register |
| pending | output | 1 | A command first half is awaiting its second |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_idx | output | 5 | Index of the last register write |
| reg_data | output | 8 | Value of the last register write |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_kind | output | 2 | Kind of the last started DMA |
| dma_len | output | 17 | Transfer count of the last started DMA |

## Verification
Two functions can meet in one cycle. The first is the release of a parked control word when dma_active falls. The second is either a fresh control write or a data-port access that arrives on that same clock. The bench lowers dma_active on the very edge at which it presents a second command word, or a data read. It then checks the result one cycle later and again two cycles later. With a second command word, the parked word must show as the open first half in the first cycle, and the fresh word must close it in the next. With a data read, the address must first show the increment with pending still low, and only then the parked command's address with pending high.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
    localparam int CODE_W = 6;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_HALF      = 2'd1,
        S_FILL      = 2'd2,
        S_FILL_HALF = 2'd3
    } cpd_state_t;

    typedef enum logic [1:0] {
        K_BUS_A = 2'b00,
        K_BUS_B = 2'b01,
        K_FILL  = 2'b10,
        K_COPY  = 2'b11
    } dma_kind_t;

    localparam logic [1:0] TOP_REGWR   = 2'b10;
    localparam logic [3:0] FILL_TARGET = 4'h1;
    localparam logic [4:0] COPY_CODE   = 5'h10;
endpackage

// File: rtl/cpd_hold.sv
module cpd_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] push_word,
    output logic              valid,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (push) begin
            valid <= 1'b1;
            word  <= push_word;
        end else if (pop) begin
            valid <= 1'b0;
        end
    end

    // R11: a release only happens with a word parked
    p_pop_needs_word_r11: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid);
    // R12: a push during a release keeps the slot occupied
    p_push_refills_r12: assert property (@(posedge clk) disable iff (rst)
        push |=> valid && word == $past(push_word));
endmodule

// File: rtl/cpd_cmd_fsm.sv
module cpd_cmd_fsm
    import cpd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 5,
    parameter int VAL_W     = 8,
    parameter int INC_W     = 8,
    parameter int REG_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eff_wr,
    input  logic [ADDR_W-1:0] eff_word,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [INC_W-1:0]  auto_inc,
    input  logic              ext_regs,
    input  logic              arm_fill,
    output logic              pending,
    output logic              fill_go,
    output logic              decide,
    output logic [CODE_W-1:0] code_nx,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [VAL_W-1:0]  reg_data
);
    localparam int LO_W = ADDR_W - 2;

    cpd_state_t       state_q, state_d;
    logic [1:0]       a_hi_q;
    logic [1:0]       top;
    logic [IDX_W-1:0] idx;
    logic             first_wr, is_regwr, reg_ok, armed, data_acc;

    assign pending = (state_q == S_HALF) || (state_q == S_FILL_HALF);

    always_comb begin
        top      = eff_word[ADDR_W-1 -: 2];
        idx      = eff_word[VAL_W +: IDX_W];
        first_wr = eff_wr && !pending;
        decide   = eff_wr && pending;
        is_regwr = first_wr && (top == TOP_REGWR);
        reg_ok   = (32'(idx) <= REG_LIMIT) || ext_regs;
        armed    = (state_q == S_FILL) || (state_q == S_FILL_HALF);
        data_acc = data_rd || data_wr;
        fill_go  = armed && data_wr;
        code_nx  = {eff_word[7:4], code[1:0]};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (first_wr && !is_regwr) state_d = S_HALF;
            end
            S_HALF: begin
                if (decide)                   state_d = arm_fill ? S_FILL : S_IDLE;
                else if (stat_rd || data_acc) state_d = S_IDLE;
            end
            S_FILL: begin
                if (fill_go)                     state_d = S_IDLE;
                else if (first_wr && !is_regwr)  state_d = S_FILL_HALF;
            end
            S_FILL_HALF: begin
                if (decide)                  state_d = S_FILL;
                else if (fill_go)            state_d = S_IDLE;
                else if (stat_rd || data_rd) state_d = S_FILL;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr     <= '0;
            code     <= '0;
            a_hi_q   <= '0;
            reg_we   <= 1'b0;
            reg_idx  <= '0;
            reg_data <= '0;
        end else begin
            reg_we <= 1'b0;
            if (first_wr) begin
                addr      <= {a_hi_q, eff_word[LO_W-1:0]};
                code[1:0] <= top;
                if (is_regwr && reg_ok) begin
                    reg_we   <= 1'b1;
                    reg_idx  <= idx;
                    reg_data <= eff_word[VAL_W-1:0];
                end
            end else if (decide) begin
                a_hi_q               <= eff_word[1:0];
                addr[ADDR_W-1 -: 2]  <= eff_word[1:0];
                code[5:2]            <= eff_word[7:4];
            end else if (data_acc && !fill_go) begin
                addr <= addr + ADDR_W'(auto_inc);
            end
        end
    end

    // R2: register write strobes once and opens no command half
    p_regwr_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        is_regwr && reg_ok |=> reg_we && reg_idx == $past(idx)
                               && reg_data == $past(eff_word[VAL_W-1:0]));
    p_regwr_no_pend_r2: assert property (@(posedge clk) disable iff (rst)
        is_regwr |=> !pending);
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we || $past(is_regwr));
    // R3: first word loads low address and low code bits
    p_first_load_r3: assert property (@(posedge clk) disable iff (rst)
        first_wr |=> addr[LO_W-1:0] == $past(eff_word[LO_W-1:0])
                     && code[1:0] == $past(top) && code[5:2] == $past(code[5:2]));
    p_first_pend_r3: assert property (@(posedge clk) disable iff (rst)
        first_wr && !is_regwr |=> pending);
    // R4: second word closes the command
    p_second_load_r4: assert property (@(posedge clk) disable iff (rst)
        decide |=> !pending && addr[ADDR_W-1 -: 2] == $past(eff_word[1:0])
                   && code[5:2] == $past(eff_word[7:4]) && code[1:0] == $past(code[1:0]));
    // R5: status read or data access clears the open half
    p_clear_pend_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd || data_acc) && !eff_wr |=> !pending);
    // R6: high registers blocked without the extension bit
    p_high_reg_block_r6: assert property (@(posedge clk) disable iff (rst)
        is_regwr && !ext_regs && (32'(idx) > REG_LIMIT) |=> !reg_we);
    // R8: the fill-starting write does not move the address
    p_fill_addr_r8: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> $stable(addr));
    // R13: ordinary data access advances the address
    p_advance_r13: assert property (@(posedge clk) disable iff (rst)
        data_acc && !fill_go && !eff_wr |=> addr == $past(addr) + ADDR_W'($past(auto_inc)));
endmodule

// File: rtl/cpd_dma_req.sv
module cpd_dma_req
    import cpd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              decide,
    input  logic              fill_go,
    input  logic [CODE_W-1:0] code_nx,
    input  logic              dma_enable,
    input  logic [1:0]        dma_mode,
    input  logic [LEN_W-1:0]  len_field,
    output logic              arm_fill,
    output logic              dma_start,
    output logic [1:0]        dma_kind,
    output logic [LEN_W:0]    dma_len
);
    logic           req, launch, start_now;
    logic [LEN_W:0] len_eff;

    always_comb begin
        req       = decide && code_nx[5] && dma_enable;
        arm_fill  = req && (dma_mode == K_FILL) && (code_nx[3:0] == FILL_TARGET);
        launch    = req && (!dma_mode[1] ||
                            ((dma_mode == K_COPY) && (code_nx[4:0] == COPY_CODE)));
        start_now = launch || fill_go;
        len_eff   = (len_field == '0) ? ((LEN_W+1)'(1) << LEN_W) : {1'b0, len_field};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_start <= 1'b0;
            dma_kind  <= '0;
            dma_len   <= '0;
        end else begin
            dma_start <= start_now;
            if (start_now) begin
                dma_kind <= fill_go ? K_FILL : dma_mode;
                dma_len  <= len_eff;
            end
        end
    end

    // R7: every start has a cause
    p_start_cause_r7: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> $past(fill_go || (decide && code_nx[5] && dma_enable)));
    p_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        decide && !(code_nx[5] && dma_enable) && !fill_go |=> !dma_start);
    // R8: fill starts with its own kind
    p_fill_kind_r8: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> dma_start && dma_kind == K_FILL);
    // R9: copy needs the exact code
    p_copy_gate_r9: assert property (@(posedge clk) disable iff (rst)
        decide && !fill_go && dma_mode == K_COPY && code_nx[4:0] != COPY_CODE |=> !dma_start);
    // R10: length is never zero at a start
    p_len_range_r10: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> dma_len != '0 && dma_len <= ((LEN_W+1)'(1) << LEN_W));
endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
    import cpd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 5,
    parameter int VAL_W     = 8,
    parameter int INC_W     = 8,
    parameter int LEN_W     = 16,
    parameter int REG_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [ADDR_W-1:0] ctrl_word,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [INC_W-1:0]  auto_inc,
    input  logic              ext_regs,
    input  logic              dma_enable,
    input  logic [1:0]        dma_mode,
    input  logic [LEN_W-1:0]  dma_len_field,
    input  logic              dma_active,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              pending,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [VAL_W-1:0]  reg_data,
    output logic              dma_start,
    output logic [1:0]        dma_kind,
    output logic [LEN_W:0]    dma_len
);
    logic              hold_valid, push, release_w, direct, eff_wr;
    logic [ADDR_W-1:0] hold_word, eff_word;
    logic              fill_go, decide, arm_fill;
    logic [CODE_W-1:0] code_nx;

    always_comb begin
        push      = ctrl_wr && (hold_valid || (!pending && dma_active));
        release_w = hold_valid && !dma_active && !(data_rd || data_wr);
        direct    = ctrl_wr && !push;
        eff_wr    = release_w || direct;
        eff_word  = release_w ? hold_word : ctrl_word;
    end

    cpd_hold #(.WORD_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (release_w),
        .push_word (ctrl_word),
        .valid     (hold_valid),
        .word      (hold_word)
    );

    cpd_cmd_fsm #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .VAL_W     (VAL_W),
        .INC_W     (INC_W),
        .REG_LIMIT (REG_LIMIT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .eff_wr   (eff_wr),
        .eff_word (eff_word),
        .stat_rd  (stat_rd),
        .data_rd  (data_rd),
        .data_wr  (data_wr),
        .auto_inc (auto_inc),
        .ext_regs (ext_regs),
        .arm_fill (arm_fill),
        .pending  (pending),
        .fill_go  (fill_go),
        .decide   (decide),
        .code_nx  (code_nx),
        .addr     (addr),
        .code     (code),
        .reg_we   (reg_we),
        .reg_idx  (reg_idx),
        .reg_data (reg_data)
    );

    cpd_dma_req #(.LEN_W(LEN_W)) u_dma (
        .clk        (clk),
        .rst        (rst),
        .decide     (decide),
        .fill_go    (fill_go),
        .code_nx    (code_nx),
        .dma_enable (dma_enable),
        .dma_mode   (dma_mode),
        .len_field  (dma_len_field),
        .arm_fill   (arm_fill),
        .dma_start  (dma_start),
        .dma_kind   (dma_kind),
        .dma_len    (dma_len)
    );

    // R11: a parked first word has no effect while the DMA runs
    p_parked_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && !pending && dma_active && !hold_valid |=> $stable(code) && !pending);
    // R12: a data access defers the release and leaves the code alone
    p_defer_release_r12: assert property (@(posedge clk) disable iff (rst)
        hold_valid && (data_rd || data_wr) && !ctrl_wr |=> $stable(code) && hold_valid);
endmodule

// File: tb/cmd_port_decoder_test.sv
`timescale 1ns/1ps
module cmd_port_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctrl_wr = 0, stat_rd = 0, data_rd = 0, data_wr = 0;
    logic [15:0] ctrl_word = '0;
    logic [7:0]  auto_inc = '0;
    logic        ext_regs = 0, dma_enable = 0, dma_active = 0;
    logic [1:0]  dma_mode = '0;
    logic [15:0] dma_len_field = '0;
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pending, reg_we, dma_start;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_data;
    logic [1:0]  dma_kind;
    logic [16:0] dma_len;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cmd_port_decoder uut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
        .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .auto_inc(auto_inc), .ext_regs(ext_regs), .dma_enable(dma_enable),
        .dma_mode(dma_mode), .dma_len_field(dma_len_field), .dma_active(dma_active),
        .addr(addr), .code(code), .pending(pending), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_data(reg_data), .dma_start(dma_start),
        .dma_kind(dma_kind), .dma_len(dma_len)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctrl(input logic [15:0] w);
        ctrl_word = w; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic drd();
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic dwr();
        data_wr = 1'b1; @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic srd();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [1:0]  m_hi;
        logic [3:0]  m_chi;
        logic [15:0] a0;
        logic [5:0]  c0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr", addr, 0);
        chk("R1 code", code, 0);
        chk("R1 pending", pending, 0);
        chk("R1 reg_we", reg_we, 0);
        chk("R1 reg_idx", reg_idx, 0);
        chk("R1 reg_data", reg_data, 0);
        chk("R1 dma_start", dma_start, 0);
        chk("R1 dma_kind", dma_kind, 0);
        chk("R1 dma_len", dma_len, 0);

        // R2 / R6 register write sweep
        for (int e = 0; e < 2; e++) begin
            ext_regs = e[0];
            for (int i = 0; i < 32; i++) begin
                logic [7:0]  v;
                logic [15:0] w;
                v = 8'((i * 37 + e * 11) & 8'hFF);
                w = 16'h8000 | 16'(i << 8) | 16'(v);
                ctrl(w);
                chk("R6 reg_we gate", reg_we, (i <= 10 || e == 1) ? 1 : 0);
                if (i <= 10 || e == 1) begin
                    chk("R2 reg_idx", reg_idx, i);
                    chk("R2 reg_data", reg_data, v);
                end
                chk("R2 pending stays", pending, 0);
                chk("R3 addr on regwr", addr, {2'b00, w[13:0]});
                chk("R3 code on regwr", code, 6'b000010);
            end
        end
        @(negedge clk);
        chk("R2 strobe single", reg_we, 0);
        ext_regs = 0;

        // R3 / R4 command sweep
        m_hi = 2'b00; m_chi = 4'h0;
        for (int h = 0; h < 4; h++) begin
            for (int c = 0; c < 16; c++) begin
                logic [1:0]  t;
                logic [13:0] lo;
                t  = (c % 3 == 2) ? 2'b11 : 2'(c % 3);
                lo = 14'((h * 1000 + c * 517) & 16'h3FFF);
                ctrl({t, lo});
                chk("R3 pending set", pending, 1);
                chk("R3 addr", addr, {m_hi, lo});
                chk("R3 code", code, {m_chi, t});
                ctrl({8'h5A, 4'(c), 2'b10, 2'(h)});
                chk("R4 pending clr", pending, 0);
                chk("R4 addr", addr, {2'(h), lo});
                chk("R4 code", code, {4'(c), t});
                chk("R7 no start without enable", dma_start, 0);
                m_hi = 2'(h); m_chi = 4'(c);
            end
        end

        // R5 / R13 data access, wrap, held top bits
        ctrl(16'h0123);
        chk("R3 held top bits", addr, 16'hC123);
        srd();
        chk("R5 status read clears", pending, 0);
        chk("R5 status read addr", addr, 16'hC123);
        auto_inc = 8'h20;
        ctrl(16'h3FF0);
        chk("R3 addr", addr, 16'hFFF0);
        drd();
        chk("R5 data read clears", pending, 0);
        chk("R13 wrap", addr, 16'h0010);
        dwr();
        chk("R13 write advance", addr, 16'h0030);
        ctrl(16'h0005);
        chk("R13 top bits unchanged", addr, 16'hC005);
        dwr();
        chk("R5 data write clears", pending, 0);
        chk("R13 advance", addr, 16'hC025);
        for (int k = 0; k < 256; k += 17) begin
            a0 = addr;
            auto_inc = 8'(k);
            drd();
            chk("R13 inc sweep", addr, 16'(a0 + 16'(k)));
        end
        auto_inc = 8'h02;

        // R7 / R10 immediate bus kinds
        dma_enable = 1;
        for (int k = 0; k < 2; k++) begin
            for (int l = 0; l < 2; l++) begin
                dma_mode = 2'(k);
                dma_len_field = (l == 0) ? 16'h0000 : 16'h0123;
                ctrl(16'h4000);
                ctrl(16'h0080);
                chk("R7 bus start", dma_start, 1);
                chk("R7 bus kind", dma_kind, k);
                chk("R10 len", dma_len, (l == 0) ? 17'h10000 : 17'h00123);
                @(negedge clk);
                chk("R7 start single", dma_start, 0);
            end
        end
        dma_mode = 2'b00;
        ctrl(16'h4000);
        ctrl(16'h0040);
        chk("R7 no start code5 clear", dma_start, 0);

        // R9 copy gate
        dma_mode = 2'b11; dma_len_field = 16'h0007;
        ctrl(16'h0000); ctrl(16'h00C0);
        chk("R9 copy start", dma_start, 1);
        chk("R9 copy kind", dma_kind, 2'b11);
        chk("R10 copy len", dma_len, 17'h7);
        ctrl(16'h4000); ctrl(16'h00C0);
        chk("R9 copy refused 0x31", dma_start, 0);
        ctrl(16'h0000); ctrl(16'h00D0);
        chk("R9 copy refused 0x34", dma_start, 0);

        // R8 fill
        dma_mode = 2'b10; dma_len_field = 16'h0040;
        ctrl(16'h4000); ctrl(16'h0080);
        chk("R8 armed no start", dma_start, 0);
        chk("R8 armed pending", pending, 0);
        a0 = addr;
        dwr();
        chk("R8 fill start", dma_start, 1);
        chk("R8 fill kind", dma_kind, 2'b10);
        chk("R10 fill len", dma_len, 17'h40);
        chk("R8 fill addr held", addr, a0);
        dwr();
        chk("R8 disarmed", dma_start, 0);
        chk("R8 disarmed advance", addr, 16'(a0 + 16'h2));
        ctrl(16'hC000); ctrl(16'h0080);
        a0 = addr;
        dwr();
        chk("R8 code 0x23 no fill", dma_start, 0);
        chk("R8 code 0x23 advance", addr, 16'(a0 + 16'h2));
        ctrl(16'h4000); ctrl(16'h0080);
        a0 = addr;
        drd();
        chk("R8 read keeps armed", dma_start, 0);
        chk("R13 read advance while armed", addr, 16'(a0 + 16'h2));
        ctrl(16'h4100);
        chk("R8 armed half open", pending, 1);
        dwr();
        chk("R8 fill from half", dma_start, 1);
        chk("R8 half closed", pending, 0);
        dma_enable = 0;

        // R11 parking
        @(negedge clk);
        c0 = code; a0 = addr;
        dma_active = 1;
        ctrl(16'h4ABC);
        chk("R11 parked code", code, c0);
        chk("R11 parked addr", addr, a0);
        chk("R11 parked pending", pending, 0);
        ctrl(16'h4DEF);
        chk("R11 still parked", pending, 0);
        dma_active = 0;
        @(negedge clk);
        chk("R11 release pending", pending, 1);
        chk("R11 newest wins", addr[13:0], 14'h0DEF);
        chk("R11 release code", code[1:0], 2'b01);
        ctrl(16'h0000);
        chk("R4 close", pending, 0);

        // R12 release meets a fresh control write
        dma_active = 1;
        ctrl(16'h0111);
        dma_active = 0;
        ctrl(16'h0020);
        chk("R12 parked first", pending, 1);
        chk("R12 parked addr", addr, 16'h0111);
        @(negedge clk);
        chk("R12 queued second", pending, 0);
        chk("R12 queued code", code, 6'h08);
        chk("R12 addr top", addr, 16'h0111);

        // R12 release meets a data access
        dma_active = 1;
        ctrl(16'h4222);
        dma_active = 0;
        drd();
        chk("R12 data served first", addr, 16'h0113);
        chk("R12 not yet released", pending, 0);
        @(negedge clk);
        chk("R12 released after", pending, 1);
        chk("R12 released addr", addr, 16'h0222);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule